// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of dedicated external interrupt pins and turns activity on them into interrupt requests. For each pin, software picks one of four sense modes: low level, any change, falling edge or rising edge. Software also sets a per-pin enable bit. In the edge modes a qualifying transition latches a sticky flag, which software clears by writing a one to it. In low-level mode the request follows the pin directly and latches nothing. The requests are presented per pin, and a registered winner is also given, with the lowest pin index ranking highest.

The I/O clock domain can be stopped. The `io_clk_run` input models that gate. While it is low, the synchronizer and edge detector are frozen, so no edge can be seen. A low-level condition on an enabled pin in level mode still raises `wake_req` through a purely combinational path from the raw pad, so a halted system can be woken. The pad value is sampled whatever its direction, so firmware can drive its own pin to raise an interrupt.

Configuration uses a small write-only register port. Address 0 holds the mode word, address 1 holds the enables, and address 2 is a write-one-to-clear strobe for the flags.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset, every mode is 00 (low level), every enable is 0 and every flag is clear. `irq_req`, `irq_top_valid` and `wake_req` are then 0 while the pins are high.
- R2: In mode 00 an enabled pin held low drives its `irq_req` bit high on the 3rd rising clock edge after the pin falls. The bit drops on the 3rd edge after the pin returns high. No flag is latched, so switching that pin to an edge mode afterwards leaves its request low.
- R3: Mode 10 sets the flag on a falling edge and mode 11 sets it on a rising edge. The `irq_req` bit rises on the 4th clock edge after the pin change. A transition in the opposite direction sets nothing.
- R4: While `io_clk_run` is 0 the synchronizer and the edge detector hold their state. A pulse that comes and goes entirely inside the gated window sets no flag, and `irq_req` does not follow the pin.
- R5: `wake_req` is the combinational OR, over all pins, of (mode 00 AND enable AND pin low). It responds whether or not `io_clk_run` is high, and it stays 0 for pins in other modes.
- R6: A set flag stays set until a write to address 2 with a 1 in that pin's bit. The request then drops one clock edge after the write edge. Other flags are not touched.
- R7: When a flag set and a clear of that flag fall on the same clock edge, the flag ends up set.
- R8: A flag is set even while its enable bit is 0. The enable only masks `irq_req`, and the request appears one edge after the enable is written.
- R9: Mode 01 sets the flag on either transition direction.
- R10: `irq_top_valid` is high exactly when any `irq_req` bit is high, in the same cycle. `irq_top_id` then gives the lowest active index.
- R11: The register map is as follows. In the mode word at address 0, pin i uses bits [2i+1:2i]. Enable bit i sits at address 1, and clear bit i at address 2. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_clk_run | input | 1 | High while the I/O clock runs; low freezes sync and edge logic |
| pin_i | input | NUM_IN | Raw pad values |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 2*NUM_IN | Register write data |
| irq_req | output | NUM_IN | Registered per-pin interrupt request |
| irq_top_valid | output | 1 | Any request active |
| irq_top_id | output | ID_W | Index of the highest-priority active request |
| wake_req | output | 1 | Asynchronous low-level wake request |

## Verification
The hardest case to reach from the ports is a flag set and its software clear landing on the same clock edge. The bench drives a falling edge at a negative edge, waits exactly two clock edges for the synchronizer, and then holds the clear write across the third edge, which is the edge where the detector fires. A second hard case is a pin pulse hidden inside a gated window. The bench stops `io_clk_run`, lets the pin fall and rise again, and restarts the clock. It then checks both that no request appears and that a later real edge is still caught.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;

endpackage

// File: rtl/eis_cfg.sv
module eis_cfg
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN = 2,
  localparam int MODE_W = 2 * NUM_IN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [NUM_IN-1:0] en_o,
  output logic [NUM_IN-1:0] clr_o
);

  logic [MODE_W-1:0] mode_q;
  logic [NUM_IN-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_MODE: mode_q <= wdata_i;
        ADDR_EN:   en_q   <= wdata_i[NUM_IN-1:0];
        default:   ;
      endcase
    end
  end

  // clear strobe is a one-cycle pulse aligned with the write
  assign clr_o  = (we_i && addr_i == ADDR_CLR) ? wdata_i[NUM_IN-1:0] : '0;
  assign mode_o = mode_q;
  assign en_o   = en_q;

  // R11: enables only move on an enable-register write
  p_en_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(we_i && addr_i == ADDR_EN) |=> $stable(en_o));

  // R11: mode word only moves on a mode-register write
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(we_i && addr_i == ADDR_MODE) |=> $stable(mode_o));

endmodule

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= {WIDTH{RST_VAL}};
    end else if (run_i) begin
      for (int s = STAGES - 1; s > 0; s--) chain_q[s] <= chain_q[s-1];
      chain_q[0] <= d_i;
    end
  end

  assign q_o = chain_q[STAGES-1];

  // R4: a stopped I/O clock freezes the synchronized value
  p_sync_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(q_o));

endmodule

// File: rtl/eis_channel.sv
module eis_channel
  import ext_irq_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       pin_s_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       req_nxt_o,
  output logic       req_o
);

  sense_e mode;
  logic   prev_q;
  logic   flag_q;
  logic   rose;
  logic   fell;
  logic   hit;
  logic   level_act;

  assign mode = sense_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst)        prev_q <= IDLE_VAL;
    else if (run_i) prev_q <= pin_s_i;
  end

  assign rose = pin_s_i & ~prev_q;
  assign fell = ~pin_s_i & prev_q;

  always_comb begin
    case (mode)
      SENSE_ANY:  hit = rose | fell;
      SENSE_FALL: hit = fell;
      SENSE_RISE: hit = rose;
      default:    hit = 1'b0;
    endcase
  end

  assign level_act = (mode == SENSE_LOW) && !pin_s_i;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)                flag_q <= 1'b0;
    else if (run_i && hit)  flag_q <= 1'b1;
    else if (clr_i)         flag_q <= 1'b0;
  end

  assign req_nxt_o = (flag_q | level_act) & en_i;

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= req_nxt_o;
  end

  // R6: flag survives until a clear strobe
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);

  // R4: no new flag while the I/O clock is stopped
  p_no_edge_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !flag_q) |=> !flag_q);

  // R2: level mode never latches a flag
  p_level_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == SENSE_LOW && !flag_q) |=> !flag_q);

  // R8: disabled input never requests
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !req_o);

endmodule

// File: rtl/eis_prio.sv
module eis_prio #(
  parameter int NUM_IN = 2,
  localparam int ID_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] req_i,
  output logic              valid_o,
  output logic [ID_W-1:0]   id_o
);

  logic [ID_W-1:0] id_d;

  always_comb begin
    id_d = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req_i[i]) id_d = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      id_o    <= '0;
    end else begin
      valid_o <= |req_i;
      id_o    <= id_d;
    end
  end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W = 2 * NUM_IN,
  localparam int ID_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_clk_run,
  input  logic [NUM_IN-1:0] pin_i,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [MODE_W-1:0] cfg_wdata,
  output logic [NUM_IN-1:0] irq_req,
  output logic              irq_top_valid,
  output logic [ID_W-1:0]   irq_top_id,
  output logic              wake_req
);

  localparam logic IDLE_VAL = 1'b1;

  logic [MODE_W-1:0] mode_w;
  logic [NUM_IN-1:0] en_w;
  logic [NUM_IN-1:0] clr_w;
  logic [NUM_IN-1:0] pin_s;
  logic [NUM_IN-1:0] req_nxt;
  logic [NUM_IN-1:0] lvl_arm;

  eis_cfg #(.NUM_IN(NUM_IN)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .mode_o  (mode_w),
    .en_o    (en_w),
    .clr_o   (clr_w)
  );

  eis_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .run_i (io_clk_run),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
    eis_channel #(.IDLE_VAL(IDLE_VAL)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .run_i     (io_clk_run),
      .pin_s_i   (pin_s[i]),
      .mode_i    (mode_w[2*i +: 2]),
      .en_i      (en_w[i]),
      .clr_i     (clr_w[i]),
      .req_nxt_o (req_nxt[i]),
      .req_o     (irq_req[i])
    );

    // asynchronous low-level arm: needs no clock at all
    assign lvl_arm[i] = (sense_e'(mode_w[2*i +: 2]) == SENSE_LOW) && en_w[i];
  end

  assign wake_req = |(lvl_arm & ~pin_i);

  eis_prio #(.NUM_IN(NUM_IN)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_nxt),
    .valid_o (irq_top_valid),
    .id_o    (irq_top_id)
  );

  // R10: winner flag tracks the request vector
  p_valid_match_r10: assert property (@(posedge clk) disable iff (rst)
    irq_top_valid == (|irq_req));

  // R10: reported winner is actually requesting
  p_grant_real_r10: assert property (@(posedge clk) disable iff (rst)
    irq_top_valid |-> irq_req[irq_top_id]);

  // R10: input 0 outranks the others
  p_low_wins_r10: assert property (@(posedge clk) disable iff (rst)
    irq_req[0] |-> (irq_top_id == '0));

  // R5: wake only from a low pin
  p_wake_needs_low_r5: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (pin_i != '1));

endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         io_clk_run = 1'b1;
  logic [N-1:0] pin_i = '1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [2*N-1:0] cfg_wdata = '0;
  logic [N-1:0] irq_req;
  logic         irq_top_valid;
  logic [0:0]   irq_top_id;
  logic         wake_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense #(.NUM_IN(N), .SYNC_STAGES(2)) u_ext_irq_sense (
    .clk           (clk),
    .rst           (rst),
    .io_clk_run    (io_clk_run),
    .pin_i         (pin_i),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .irq_req       (irq_req),
    .irq_top_valid (irq_top_valid),
    .irq_top_id    (irq_top_id),
    .wake_req      (wake_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negative edge; the write lands on the next rising edge
  task automatic cfg_write(input logic [1:0] a, input logic [2*N-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic do_reset();
    pin_i = '1; io_clk_run = 1'b1; cfg_we = 1'b0;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq_req after reset", 32'(irq_req), 0);
    chk("R1 top_valid after reset", 32'(irq_top_valid), 0);
    chk("R1 wake_req after reset", 32'(wake_req), 0);
  endtask

  task automatic t_level();
    do_reset();
    cfg_write(2'd1, 4'b0001);
    pin_i[0] = 1'b0;
    #1 chk("R5 wake on low level", 32'(wake_req), 1);
    tick(2); chk("R2 level not yet", 32'(irq_req), 0);
    tick(1); chk("R2 level request", 32'(irq_req), 1);
    pin_i[0] = 1'b1;
    #1 chk("R5 wake drops with pin", 32'(wake_req), 0);
    tick(2); chk("R2 level still held", 32'(irq_req), 1);
    tick(1); chk("R2 level released", 32'(irq_req), 0);
    cfg_write(2'd0, 4'b0010);
    tick(3); chk("R2 no latched flag", 32'(irq_req), 0);
  endtask

  task automatic t_gated_level();
    do_reset();
    cfg_write(2'd1, 4'b0011);
    io_clk_run = 1'b0;
    pin_i[1] = 1'b0;
    #1 chk("R5 wake while gated", 32'(wake_req), 1);
    tick(5); chk("R4 request frozen while gated", 32'(irq_req), 0);
    pin_i[1] = 1'b1;
    #1 chk("R5 wake clears while gated", 32'(wake_req), 0);
    cfg_write(2'd0, 4'b0010);
    pin_i[0] = 1'b0;
    #1 chk("R5 no wake in edge mode", 32'(wake_req), 0);
    io_clk_run = 1'b1;
  endtask

  task automatic t_edge();
    do_reset();
    cfg_write(2'd0, 4'b1110);
    cfg_write(2'd1, 4'b0011);
    pin_i[1] = 1'b0;
    tick(6); chk("R3 rising mode ignores fall", 32'(irq_req), 0);
    pin_i[0] = 1'b0;
    tick(3); chk("R3 falling not yet", 32'(irq_req), 0);
    tick(1); chk("R3 falling edge request", 32'(irq_req), 1);
    pin_i[0] = 1'b1;
    tick(6); chk("R6 flag sticky after pin returns", 32'(irq_req), 1);
    pin_i[1] = 1'b1;
    tick(3); chk("R3 rising not yet", 32'(irq_req), 1);
    tick(1); chk("R3 rising edge request", 32'(irq_req), 3);
    cfg_write(2'd2, 4'b0001);
    chk("R6 request before clear takes effect", 32'(irq_req), 3);
    tick(1); chk("R6 only flag 0 cleared", 32'(irq_req), 2);
  endtask

  task automatic t_set_wins();
    do_reset();
    cfg_write(2'd0, 4'b0010);
    cfg_write(2'd1, 4'b0001);
    pin_i[0] = 1'b0;
    tick(2);
    cfg_write(2'd2, 4'b0001);
    tick(1); chk("R7 set beats clear", 32'(irq_req), 1);
    tick(3); chk("R7 flag remains", 32'(irq_req), 1);
  endtask

  task automatic t_mask();
    do_reset();
    cfg_write(2'd0, 4'b0010);
    pin_i[0] = 1'b0;
    tick(6); chk("R8 masked request", 32'(irq_req), 0);
    cfg_write(2'd1, 4'b0001);
    tick(1); chk("R8 flag set while disabled", 32'(irq_req), 1);
    cfg_write(2'd1, 4'b0000);
    tick(1); chk("R8 disable masks again", 32'(irq_req), 0);
  endtask

  task automatic t_any();
    do_reset();
    cfg_write(2'd0, 4'b0001);
    cfg_write(2'd1, 4'b0001);
    pin_i[0] = 1'b0;
    tick(4); chk("R9 any change on fall", 32'(irq_req), 1);
    cfg_write(2'd2, 4'b0001);
    tick(1); chk("R9 cleared", 32'(irq_req), 0);
    pin_i[0] = 1'b1;
    tick(4); chk("R9 any change on rise", 32'(irq_req), 1);
  endtask

  task automatic t_prio();
    do_reset();
    cfg_write(2'd0, 4'b1010);
    cfg_write(2'd1, 4'b0011);
    pin_i[1] = 1'b0;
    tick(4);
    chk("R10 req input 1 only", 32'(irq_req), 2);
    chk("R10 valid", 32'(irq_top_valid), 1);
    chk("R10 id is 1", 32'(irq_top_id), 1);
    pin_i[0] = 1'b0;
    tick(4);
    chk("R10 both requesting", 32'(irq_req), 3);
    chk("R10 input 0 wins", 32'(irq_top_id), 0);
    cfg_write(2'd2, 4'b0001);
    tick(1);
    chk("R10 back to input 1", 32'(irq_top_id), 1);
    cfg_write(2'd2, 4'b0010);
    tick(1);
    chk("R10 no winner", 32'(irq_top_valid), 0);
  endtask

  task automatic t_gated_edge();
    do_reset();
    cfg_write(2'd0, 4'b0010);
    cfg_write(2'd1, 4'b0001);
    io_clk_run = 1'b0;
    pin_i[0] = 1'b0;
    tick(3);
    pin_i[0] = 1'b1;
    tick(3); chk("R4 no request while gated", 32'(irq_req), 0);
    io_clk_run = 1'b1;
    tick(6); chk("R4 gated pulse missed", 32'(irq_req), 0);
    pin_i[0] = 1'b0;
    tick(4); chk("R4 edge seen once clock runs", 32'(irq_req), 1);
  endtask

  task automatic t_map();
    do_reset();
    cfg_write(2'd0, 4'b0010);
    cfg_write(2'd1, 4'b0001);
    pin_i[0] = 1'b0;
    tick(4); chk("R11 flag via mode bits 1:0", 32'(irq_req), 1);
    cfg_write(2'd3, 4'b1111);
    tick(2); chk("R11 address 3 ignored", 32'(irq_req), 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_level();
    t_gated_level();
    t_edge();
    t_set_wins();
    t_mask();
    t_any();
    t_prio();
    t_gated_edge();
    t_map();
    finish_run();
  end

endmodule